// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Flags

This block holds the sample buffering for a serial audio port: one 8-word by 32-bit first-in first-out store carries words from software towards the serializer (transmit), a second one carries words from the deserializer towards software (receive). Both share one core design. The transmit core drops a word offered while full. The receive core, when a word arrives while full, discards its oldest entry to make room.

Each direction reports its fill level, full and empty, and a programmable threshold flag. It also reports sticky overflow and underflow flags that software clears by writing 1. A clear command rewinds the pointers of a direction without erasing its storage. DMA request lines follow the fill state. Interrupt lines combine the flags with per-flag enables. The serializer and bus decoding sit outside this block.

Data ports are valid/ready. On the software transmit side, `sw_tx_ready` is high while the transmit store is not full. A word offered with `sw_tx_valid` while ready is low is lost and counts as an overflow. On the shifter transmit side, `sh_tx_valid` is high while words are stored, and `sh_tx_ready` takes the head word. A take while valid is low is an underflow. The shifter receive side has no back-pressure: every `sh_rx_valid` word is accepted. On the software receive side, `sw_rx_valid` marks stored data, and `sw_rx_ready` reads the head word. A read while valid is low is an underflow.

Top module: `snd_fifo_pair`

## Requirements
- R1: After reset both stores are empty (level 0, empty 1, full 0) and all sticky flags are 0. The 4-bit level counts stored words from 0 to 8, with full exactly at 8 and empty exactly at 0, and `sw_tx_ready` equals not-full.
- R2: Words leave each store in the order they were accepted. An accepted write and a successful take in the same cycle leave the level unchanged.
- R3: `tx_thr` is high while the transmit level is less than or equal to the 3-bit code `tx_thr_code`, so code 0 flags only an empty store.
- R4: `rx_thr` is high while the receive level is at least `rx_thr_code` + 1, so code 0 means 1 word and code 7 means 8 words.
- R5: A `tx_clr` or `rx_clr` pulse sets that level to 0 on the next edge and rewinds its pointers. Words written afterwards come out in order, starting with the first word written after the clear.
- R6: A transmit write while full is dropped, keeps the level at 8 and sets `tx_ovf`. A transmit take while empty leaves the level at 0 and sets `tx_udf`.
- R7: A receive push while full, with no read in that cycle, overwrites the oldest word, keeps the level at 8 and sets `rx_ovf`. A software read while empty sets `rx_udf`.
- R8: The four error flags stay set until a 1 on their clear input. A new error in the same cycle as the clear leaves the flag set.
- R9: `tx_dma_req` equals `tx_dma_en` AND not transmit full. `rx_dma_req` equals `rx_dma_en` AND not receive empty.
- R10: `tx_irq` is the OR of each transmit flag (overflow, underflow, threshold) ANDed with its enable. `rx_irq` is formed the same way for receive, and `irq` is `tx_irq` OR `rx_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_tx_valid | input | 1 | Software offers a transmit word |
| sw_tx_ready | output | 1 | Transmit store can accept a word |
| sw_tx_data | input | 32 | Transmit word from software |
| sh_tx_valid | output | 1 | Transmit head word is available |
| sh_tx_ready | input | 1 | Shifter takes the transmit head word |
| sh_tx_data | output | 32 | Transmit head word |
| sh_rx_valid | input | 1 | Deserializer delivers a receive word |
| sh_rx_data | input | 32 | Receive word from deserializer |
| sw_rx_valid | output | 1 | Receive head word is available |
| sw_rx_ready | input | 1 | Software reads the receive head word |
| sw_rx_data | output | 32 | Receive head word |
| tx_clr | input | 1 | Rewind transmit pointers |
| rx_clr | input | 1 | Rewind receive pointers |
| tx_thr_code | input | 3 | Transmit threshold code |
| rx_thr_code | input | 3 | Receive threshold code |
| tx_dma_en | input | 1 | Transmit DMA request enable |
| rx_dma_en | input | 1 | Receive DMA request enable |
| ie_tx_ovf | input | 1 | Transmit overflow interrupt enable |
| ie_tx_udf | input | 1 | Transmit underflow interrupt enable |
| ie_tx_thr | input | 1 | Transmit threshold interrupt enable |
| ie_rx_ovf | input | 1 | Receive overflow interrupt enable |
| ie_rx_udf | input | 1 | Receive underflow interrupt enable |
| ie_rx_thr | input | 1 | Receive threshold interrupt enable |
| tx_ovf_w1c | input | 1 | Clear transmit overflow flag |
| tx_udf_w1c | input | 1 | Clear transmit underflow flag |
| rx_ovf_w1c | input | 1 | Clear receive overflow flag |
| rx_udf_w1c | input | 1 | Clear receive underflow flag |
| tx_level | output | 4 | Transmit words stored |
| tx_full | output | 1 | Transmit store full |
| tx_empty | output | 1 | Transmit store empty |
| tx_thr | output | 1 | Transmit threshold flag |
| tx_ovf | output | 1 | Transmit overflow sticky flag |
| tx_udf | output | 1 | Transmit underflow sticky flag |
| rx_level | output | 4 | Receive words stored |
| rx_full | output | 1 | Receive store full |
| rx_empty | output | 1 | Receive store empty |
| rx_thr | output | 1 | Receive threshold flag |
| rx_ovf | output | 1 | Receive overflow sticky flag |
| rx_udf | output | 1 | Receive underflow sticky flag |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong read pointer shows up at the head-data port at the next take, because the word delivered no longer matches the scoreboard's oldest entry. A miscounted level shows up one edge later as a wrong level or full/empty value, and in the threshold and DMA lines that decode it in the same cycle. A wrong overwrite decision on receive overflow shows up only when the store is drained, as a missing or repeated word, so the bench always reads the whole store back after an overflow. Sticky-flag errors show one edge after the causing event, or after the clear pulse.

// File: rtl/snd_fifo_pkg.sv
package snd_fifo_pkg;
  localparam int SND_DATA_W = 32;
  localparam int SND_DEPTH  = 8;
  localparam int SND_CODE_W = 3;

  typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} snd_dir_e;

  localparam int FLG_TX_OVF = 0;
  localparam int FLG_TX_UDF = 1;
  localparam int FLG_RX_OVF = 2;
  localparam int FLG_RX_UDF = 3;
  localparam int FLG_NUM    = 4;
endpackage

// File: rtl/snd_fifo_core.sv
module snd_fifo_core #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 8,
  parameter bit OVERWRITE = 1'b0,
  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output logic              ovf_evt,
  output logic              udf_evt
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rptr, wptr;
  logic              do_push, do_pop, drop_old, adv_rd;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign full  = (level == FULL_LVL);
  assign empty = (level == '0);

  assign do_pop = pop && !empty && !clr;

  generate
    if (OVERWRITE) begin : g_ovw
      assign do_push  = push && !clr;
      assign drop_old = push && full && !pop && !clr;
    end else begin : g_drop
      assign do_push  = push && !full && !clr;
      assign drop_old = 1'b0;
    end
  endgenerate

  assign adv_rd  = do_pop || drop_old;
  assign ovf_evt = push && full && !clr && !(OVERWRITE && pop);
  assign udf_evt = pop && empty && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      level <= '0;
    end else if (clr) begin
      rptr  <= '0;
      wptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (adv_rd)  rptr <= bump(rptr);
      if (do_push && !adv_rd)      level <= level + 1'b1;
      else if (!do_push && adv_rd) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  assign head_data = mem[rptr];

  // R1
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);

  // R5
  clr_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (level == '0));

  // R2
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && !empty && !clr) |=> $stable(level));

  // R6
  full_write_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (level == FULL_LVL));

  // R6
  empty_take_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !clr) |=> (level == '0));
endmodule

// File: rtl/snd_w1c_flag.sv
module snd_w1c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic w1c,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set | (flag & ~w1c);
  end

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !w1c) |=> flag);
endmodule

// File: rtl/snd_dir_status.sv
module snd_dir_status
  import snd_fifo_pkg::*;
#(
  parameter snd_dir_e DIR   = DIR_TX,
  parameter int       LVL_W = 4,
  parameter int       CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  level,
  input  logic              full,
  input  logic              empty,
  input  logic [CODE_W-1:0] thr_code,
  input  logic              dma_en,
  input  logic              ovf,
  input  logic              udf,
  input  logic              ie_ovf,
  input  logic              ie_udf,
  input  logic              ie_thr,
  output logic              thr_flag,
  output logic              dma_req,
  output logic              irq
);
  localparam int CMP_W = ((LVL_W > CODE_W) ? LVL_W : CODE_W) + 1;

  logic [CMP_W-1:0] lvl_x, code_x;
  assign lvl_x  = CMP_W'(level);
  assign code_x = CMP_W'(thr_code);

  generate
    if (DIR == DIR_RX) begin : g_rx
      assign thr_flag = (lvl_x >= code_x + 1'b1);
      assign dma_req  = dma_en && !empty;
    end else begin : g_tx
      assign thr_flag = (lvl_x <= code_x);
      assign dma_req  = dma_en && !full;
    end
  endgenerate

  assign irq = (ovf & ie_ovf) | (udf & ie_udf) | (thr_flag & ie_thr);

  generate
    if (DIR == DIR_RX) begin : g_rx_chk
      // R4
      rx_full_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> thr_flag);
      // R4
      rx_empty_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !thr_flag);
    end else begin : g_tx_chk
      // R3
      tx_empty_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> thr_flag);
    end
  endgenerate
endmodule

// File: rtl/snd_fifo_pair.sv
module snd_fifo_pair
  import snd_fifo_pkg::*;
#(
  parameter int DATA_W = SND_DATA_W,
  parameter int DEPTH  = SND_DEPTH,
  parameter int CODE_W = SND_CODE_W,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_tx_valid,
  output logic              sw_tx_ready,
  input  logic [DATA_W-1:0] sw_tx_data,
  output logic              sh_tx_valid,
  input  logic              sh_tx_ready,
  output logic [DATA_W-1:0] sh_tx_data,
  input  logic              sh_rx_valid,
  input  logic [DATA_W-1:0] sh_rx_data,
  output logic              sw_rx_valid,
  input  logic              sw_rx_ready,
  output logic [DATA_W-1:0] sw_rx_data,
  input  logic              tx_clr,
  input  logic              rx_clr,
  input  logic [CODE_W-1:0] tx_thr_code,
  input  logic [CODE_W-1:0] rx_thr_code,
  input  logic              tx_dma_en,
  input  logic              rx_dma_en,
  input  logic              ie_tx_ovf,
  input  logic              ie_tx_udf,
  input  logic              ie_tx_thr,
  input  logic              ie_rx_ovf,
  input  logic              ie_rx_udf,
  input  logic              ie_rx_thr,
  input  logic              tx_ovf_w1c,
  input  logic              tx_udf_w1c,
  input  logic              rx_ovf_w1c,
  input  logic              rx_udf_w1c,
  output logic [LVL_W-1:0]  tx_level,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              tx_thr,
  output logic              tx_ovf,
  output logic              tx_udf,
  output logic [LVL_W-1:0]  rx_level,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              rx_thr,
  output logic              rx_ovf,
  output logic              rx_udf,
  output logic              tx_dma_req,
  output logic              rx_dma_req,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              irq
);
  logic [FLG_NUM-1:0] flg_set, flg_w1c, flg_q;

  snd_fifo_core #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OVERWRITE(1'b0)) u_tx_core (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(sw_tx_valid), .push_data(sw_tx_data), .pop(sh_tx_ready),
    .head_data(sh_tx_data), .level(tx_level), .full(tx_full), .empty(tx_empty),
    .ovf_evt(flg_set[FLG_TX_OVF]), .udf_evt(flg_set[FLG_TX_UDF])
  );

  snd_fifo_core #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OVERWRITE(1'b1)) u_rx_core (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(sh_rx_valid), .push_data(sh_rx_data), .pop(sw_rx_ready),
    .head_data(sw_rx_data), .level(rx_level), .full(rx_full), .empty(rx_empty),
    .ovf_evt(flg_set[FLG_RX_OVF]), .udf_evt(flg_set[FLG_RX_UDF])
  );

  assign sw_tx_ready = !tx_full;
  assign sh_tx_valid = !tx_empty;
  assign sw_rx_valid = !rx_empty;

  assign flg_w1c[FLG_TX_OVF] = tx_ovf_w1c;
  assign flg_w1c[FLG_TX_UDF] = tx_udf_w1c;
  assign flg_w1c[FLG_RX_OVF] = rx_ovf_w1c;
  assign flg_w1c[FLG_RX_UDF] = rx_udf_w1c;

  generate
    for (genvar g = 0; g < FLG_NUM; g++) begin : g_flag
      snd_w1c_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set(flg_set[g]), .w1c(flg_w1c[g]), .flag(flg_q[g])
      );
    end
  endgenerate

  assign tx_ovf = flg_q[FLG_TX_OVF];
  assign tx_udf = flg_q[FLG_TX_UDF];
  assign rx_ovf = flg_q[FLG_RX_OVF];
  assign rx_udf = flg_q[FLG_RX_UDF];

  snd_dir_status #(.DIR(DIR_TX), .LVL_W(LVL_W), .CODE_W(CODE_W)) u_tx_stat (
    .clk(clk), .rst_n(rst_n), .level(tx_level), .full(tx_full), .empty(tx_empty),
    .thr_code(tx_thr_code), .dma_en(tx_dma_en), .ovf(tx_ovf), .udf(tx_udf),
    .ie_ovf(ie_tx_ovf), .ie_udf(ie_tx_udf), .ie_thr(ie_tx_thr),
    .thr_flag(tx_thr), .dma_req(tx_dma_req), .irq(tx_irq)
  );

  snd_dir_status #(.DIR(DIR_RX), .LVL_W(LVL_W), .CODE_W(CODE_W)) u_rx_stat (
    .clk(clk), .rst_n(rst_n), .level(rx_level), .full(rx_full), .empty(rx_empty),
    .thr_code(rx_thr_code), .dma_en(rx_dma_en), .ovf(rx_ovf), .udf(rx_udf),
    .ie_ovf(ie_rx_ovf), .ie_udf(ie_rx_udf), .ie_thr(ie_rx_thr),
    .thr_flag(rx_thr), .dma_req(rx_dma_req), .irq(rx_irq)
  );

  assign irq = tx_irq | rx_irq;

  // R9
  tx_dma_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_dma_req);

  // R9
  rx_dma_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> !rx_dma_req);

  // R10
  irq_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_ovf && ie_tx_ovf) || (rx_ovf && ie_rx_ovf)) |-> irq);

  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (tx_empty && rx_empty));
endmodule

// File: tb/snd_fifo_pair_tb_top.sv
module snd_fifo_pair_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        sw_tx_valid = 0, sh_tx_ready = 0, sh_rx_valid = 0, sw_rx_ready = 0;
  logic [31:0] sw_tx_data = '0, sh_rx_data = '0;
  logic        tx_clr = 0, rx_clr = 0;
  logic [2:0]  tx_thr_code = '0, rx_thr_code = '0;
  logic        tx_dma_en = 0, rx_dma_en = 0;
  logic        ie_tx_ovf = 0, ie_tx_udf = 0, ie_tx_thr = 0;
  logic        ie_rx_ovf = 0, ie_rx_udf = 0, ie_rx_thr = 0;
  logic        tx_ovf_w1c = 0, tx_udf_w1c = 0, rx_ovf_w1c = 0, rx_udf_w1c = 0;
  logic        sw_tx_ready, sh_tx_valid, sw_rx_valid;
  logic [31:0] sh_tx_data, sw_rx_data;
  logic [3:0]  tx_level, rx_level;
  logic        tx_full, tx_empty, tx_thr, tx_ovf, tx_udf;
  logic        rx_full, rx_empty, rx_thr, rx_ovf, rx_udf;
  logic        tx_dma_req, rx_dma_req, tx_irq, rx_irq, irq;

  snd_fifo_pair dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // driver: offer a transmit word, scoreboard keeps it if it fits
  task automatic tx_put(logic [31:0] d);
    sw_tx_valid = 1; sw_tx_data = d;
    if (txq.size() < 8) txq.push_back(d);
    cyc();
    sw_tx_valid = 0;
  endtask

  // monitor: take the transmit head and compare with the oldest expected word
  task automatic tx_take(string req);
    sh_tx_ready = 1;
    if (txq.size() > 0) begin
      chk(req, 32'(sh_tx_valid), 32'd1);
      chk(req, sh_tx_data, txq.pop_front());
    end
    cyc();
    sh_tx_ready = 0;
  endtask

  task automatic rx_put(logic [31:0] d);
    sh_rx_valid = 1; sh_rx_data = d;
    if (rxq.size() == 8) void'(rxq.pop_front());
    rxq.push_back(d);
    cyc();
    sh_rx_valid = 0;
  endtask

  task automatic rx_take(string req);
    sw_rx_ready = 1;
    if (rxq.size() > 0) begin
      chk(req, 32'(sw_rx_valid), 32'd1);
      chk(req, sw_rx_data, rxq.pop_front());
    end
    cyc();
    sw_rx_ready = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 tx_level", 32'(tx_level), 0);
    chk("R1 tx_empty", 32'(tx_empty), 1);
    chk("R1 rx_empty", 32'(rx_empty), 1);
    chk("R1 flags", 32'({tx_ovf, tx_udf, rx_ovf, rx_udf}), 0);
    chk("R1 sw_tx_ready", 32'(sw_tx_ready), 1);

    // R3 threshold code 0 flags only empty
    tx_thr_code = 3'd0; #1;
    chk("R3 code0 empty", 32'(tx_thr), 1);
    tx_thr_code = 3'd2;
    for (int i = 0; i < 8; i++) begin
      tx_put(32'hA000 + 32'(i));
      chk("R1 tx_level fill", 32'(tx_level), 32'(i + 1));
      chk("R3 tx_thr", 32'(tx_thr), 32'((i + 1) <= 2));
    end
    chk("R1 tx_full", 32'(tx_full), 1);
    chk("R1 sw_tx_ready full", 32'(sw_tx_ready), 0);
    tx_dma_en = 1; #1;
    chk("R9 tx_dma full", 32'(tx_dma_req), 0);

    // R6 write while full is dropped
    tx_put(32'hDEAD);
    chk("R6 tx_ovf", 32'(tx_ovf), 1);
    chk("R6 tx_level stays 8", 32'(tx_level), 8);
    tx_take("R2 order");
    chk("R9 tx_dma not full", 32'(tx_dma_req), 1);

    // R2 simultaneous write and take
    sh_tx_ready = 1;
    chk("R2 simul head", sh_tx_data, txq.pop_front());
    sw_tx_valid = 1; sw_tx_data = 32'hB000; txq.push_back(32'hB000);
    cyc();
    sw_tx_valid = 0; sh_tx_ready = 0;
    chk("R2 simul level", 32'(tx_level), 7);
    for (int i = 0; i < 7; i++) tx_take("R2 drain");
    chk("R1 tx_empty drained", 32'(tx_empty), 1);

    // R6 take while empty
    chk("R6 tx_udf before", 32'(tx_udf), 0);
    sh_tx_ready = 1; cyc(); sh_tx_ready = 0;
    chk("R6 tx_udf", 32'(tx_udf), 1);
    chk("R6 tx_level 0", 32'(tx_level), 0);

    // R10 interrupt enables
    chk("R10 tx_irq masked", 32'(tx_irq), 0);
    ie_tx_udf = 1; #1;
    chk("R10 tx_irq", 32'(tx_irq), 1);
    chk("R10 irq", 32'(irq), 1);
    ie_tx_udf = 0; ie_tx_thr = 1; #1;
    chk("R10 tx_irq thr", 32'(tx_irq), 1);
    ie_tx_thr = 0;

    // R8 set wins over clear, then clear alone
    sh_tx_ready = 1; tx_udf_w1c = 1; cyc(); sh_tx_ready = 0;
    chk("R8 set wins", 32'(tx_udf), 1);
    cyc(); tx_udf_w1c = 0;
    chk("R8 w1c clears", 32'(tx_udf), 0);
    chk("R8 ovf sticky", 32'(tx_ovf), 1);
    tx_ovf_w1c = 1; cyc(); tx_ovf_w1c = 0;
    chk("R8 ovf cleared", 32'(tx_ovf), 0);

    // R5 transmit clear
    tx_put(32'hC0); tx_put(32'hC1); tx_put(32'hC2);
    tx_clr = 1; txq.delete(); cyc(); tx_clr = 0;
    chk("R5 tx_level", 32'(tx_level), 0);
    chk("R5 tx_empty", 32'(tx_empty), 1);
    tx_put(32'hD0); tx_put(32'hD1);
    tx_take("R5 order"); tx_take("R5 order");

    // R4 receive threshold, R9 receive DMA
    rx_thr_code = 3'd3; rx_dma_en = 1; #1;
    chk("R9 rx_dma empty", 32'(rx_dma_req), 0);
    chk("R4 rx_thr empty", 32'(rx_thr), 0);
    for (int i = 0; i < 3; i++) rx_put(32'hE000 + 32'(i));
    chk("R4 rx_thr lvl3", 32'(rx_thr), 0);
    chk("R9 rx_dma", 32'(rx_dma_req), 1);
    rx_put(32'hE003);
    chk("R4 rx_thr lvl4", 32'(rx_thr), 1);
    for (int i = 4; i < 8; i++) rx_put(32'hE000 + 32'(i));
    chk("R1 rx_full", 32'(rx_full), 1);
    rx_thr_code = 3'd7; #1;
    chk("R4 code7 full", 32'(rx_thr), 1);

    // R7 overwrite oldest
    rx_put(32'hE008);
    chk("R7 rx_level", 32'(rx_level), 8);
    chk("R7 rx_ovf", 32'(rx_ovf), 1);
    rx_take("R7 order");
    chk("R4 code7 lvl7", 32'(rx_thr), 0);
    for (int i = 0; i < 7; i++) rx_take("R7 order");
    chk("R7 rx_empty", 32'(rx_empty), 1);
    sw_rx_ready = 1; cyc(); sw_rx_ready = 0;
    chk("R7 rx_udf", 32'(rx_udf), 1);
    ie_rx_udf = 1; #1;
    chk("R10 rx_irq", 32'(rx_irq), 1);
    chk("R10 tx_irq idle", 32'(tx_irq), 0);
    chk("R10 irq rx", 32'(irq), 1);
    ie_rx_udf = 0;

    // R5 receive clear
    rx_put(32'hF0); rx_put(32'hF1);
    rx_clr = 1; rxq.delete(); cyc(); rx_clr = 0;
    chk("R5 rx_level", 32'(rx_level), 0);
    rx_put(32'hF5);
    rx_take("R5 rx order");
    chk("R5 rx_empty", 32'(rx_empty), 1);

    finish_run();
  end
endmodule